// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a simple 32-bit pipeline front end. Each cycle it takes decoded control-flow information for the instruction currently at the PC and chooses the next fetch address. It can advance sequentially, take a conditional branch relative to the following instruction, jump within the current 256 MB region, or jump to an address held in a register. It also supplies the return address that call-type instructions write back. A misalignment flag marks register jumps to addresses that are not word aligned.

The decoder presents a 3-bit control kind together with the already sign-extended branch offset, the 26-bit jump field, the first source register value, and the equality result of the two source registers. A plain stall input freezes the PC. There is no streaming interface: all pins are level controls sampled at the rising clock edge. The block models no delay slot. A taken control transfer changes the PC on the very next edge.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes `RESET_VEC` (default 0) and `misalign` becomes 0 on that edge.
- R2: With `stall` low and `kind` = 0 (sequential), `pc` advances by 4 at each edge, wrapping modulo 2^32.
- R3: With `stall` high, `pc` keeps its value whatever `kind` and the data inputs carry, and `misalign` is 0 after that edge.
- R4: With `kind` = 1 (branch on equal), `pc` becomes `pc + 4 + 4*offset` when `rs_eq_rt` is 1, and `pc + 4` when it is 0.
- R5: With `kind` = 2 (branch on not equal), `pc` becomes `pc + 4 + 4*offset` when `rs_eq_rt` is 0, and `pc + 4` when it is 1.
- R6: With `kind` = 3 (region jump), `pc` becomes {pc[31:28], jfield, 2'b00}; the top four bits are kept.
- R7: With `kind` = 4 (register jump), `pc` becomes `rs_val` unchanged, including its low two bits.
- R8: `misalign` is 1 for exactly the one cycle after an unstalled register jump whose `rs_val[1:0]` is not 00, and 0 otherwise.
- R9: `link` always equals `pc + 4` modulo 2^32 for the current `pc`.
- R10: The `kind` codes 5, 6 and 7 behave as sequential advance and never raise `misalign`.
- R11: Negative offsets branch backwards, and the branch target is computed modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the PC this cycle |
| kind | input | 3 | Control kind: 0 seq, 1 beq, 2 bne, 3 region jump, 4 register jump |
| offset | input | 32 | Sign-extended 16-bit branch offset in words |
| jfield | input | 26 | Region jump word index |
| rs_val | input | 32 | First source register value |
| rs_eq_rt | input | 1 | 1 when the two source registers are equal |
| pc | output | 32 | Current program counter |
| link | output | 32 | Return address, PC + 4 |
| misalign | output | 1 | Register jump target was not word aligned |

## Verification
The hardest states to reach from the ports are PCs near the top of the address space and PCs with nonzero low bits. Sequential stepping alone would need billions of cycles to get there. The bench therefore uses a register jump to place the PC at arbitrary values, such as 0xFFFFFFF8 or a misaligned address. From there it exercises wrap-around of the increment, the branch target and the link value, and checks that region jumps keep the upper PC bits. Stall cycles are interleaved with pending jumps to show that a held jump neither moves the PC nor raises the flag.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    NK_SEQ   = 3'd0,
    NK_BEQ   = 3'd1,
    NK_BNE   = 3'd2,
    NK_JABS  = 3'd3,
    NK_JREG  = 3'd4
  } npc_kind_e;
endpackage

// File: rtl/npc_adder.sv
module npc_adder #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] pc_plus,
  output logic [XLEN-1:0] br_target
);
  localparam int SCALE_SH = $clog2(STEP);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  always_comb begin
    pc_plus   = pc + STEP_V;
    br_target = pc_plus + (offset << SCALE_SH);
  end
endmodule

// File: rtl/npc_target_sel.sv
module npc_target_sel
  import npc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int JF_W = 26,
  parameter int ALIGN_W = 2
) (
  input  npc_kind_e       kind,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] pc_plus,
  input  logic [XLEN-1:0] br_target,
  input  logic [JF_W-1:0] jfield,
  input  logic [XLEN-1:0] rs_val,
  input  logic            rs_eq_rt,
  output logic [XLEN-1:0] next_pc,
  output logic            misalign_req
);
  localparam int REGION_W = XLEN - JF_W - ALIGN_W;

  logic [XLEN-1:0] region_target;

  generate
    if (REGION_W > 0) begin : g_region
      assign region_target = {pc[XLEN-1 -: REGION_W], jfield, {ALIGN_W{1'b0}}};
    end else begin : g_flat
      assign region_target = XLEN'({jfield, {ALIGN_W{1'b0}}});
    end
  endgenerate

  always_comb begin
    next_pc      = pc_plus;
    misalign_req = 1'b0;
    case (kind)
      NK_BEQ:  if (rs_eq_rt)  next_pc = br_target;
      NK_BNE:  if (!rs_eq_rt) next_pc = br_target;
      NK_JABS: next_pc = region_target;
      NK_JREG: begin
        next_pc      = rs_val;
        misalign_req = |rs_val[ALIGN_W-1:0];
      end
      default: next_pc = pc_plus;
    endcase
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [XLEN-1:0] next_pc,
  input  logic            misalign_req,
  output logic [XLEN-1:0] pc,
  output logic            misalign
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= RESET_VEC;
      misalign <= 1'b0;
    end else if (stall) begin
      misalign <= 1'b0;
    end else begin
      pc       <= next_pc;
      misalign <= misalign_req;
    end
  end

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    stall |=> (pc == $past(pc)) && !misalign);

  assert_reset_vec_R1: assert property (@(posedge clk)
    rst |=> (pc == RESET_VEC) && !misalign);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int JF_W = 26,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [2:0]      kind,
  input  logic [XLEN-1:0] offset,
  input  logic [JF_W-1:0] jfield,
  input  logic [XLEN-1:0] rs_val,
  input  logic            rs_eq_rt,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] link,
  output logic            misalign
);
  localparam int ALIGN_W = 2;
  localparam int STEP    = 1 << ALIGN_W;
  localparam int REGION_W = XLEN - JF_W - ALIGN_W;

  logic [XLEN-1:0] pc_plus, br_target, next_pc;
  logic            misalign_req;
  npc_kind_e       kind_e;

  assign kind_e = npc_kind_e'(kind);

  npc_adder #(.XLEN(XLEN), .STEP(STEP)) u_adder (
    .pc(pc), .offset(offset), .pc_plus(pc_plus), .br_target(br_target)
  );

  npc_target_sel #(.XLEN(XLEN), .JF_W(JF_W), .ALIGN_W(ALIGN_W)) u_sel (
    .kind(kind_e), .pc(pc), .pc_plus(pc_plus), .br_target(br_target),
    .jfield(jfield), .rs_val(rs_val), .rs_eq_rt(rs_eq_rt),
    .next_pc(next_pc), .misalign_req(misalign_req)
  );

  npc_pc_reg #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_reg (
    .clk(clk), .rst(rst), .stall(stall), .next_pc(next_pc),
    .misalign_req(misalign_req), .pc(pc), .misalign(misalign)
  );

  assign link = pc_plus;

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall && kind == 3'd0) |=> pc == $past(pc) + XLEN'(STEP));

  assert_beq_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (!stall && kind == 3'd1 && !rs_eq_rt) |=> pc == $past(pc) + XLEN'(STEP));

  assert_bne_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (!stall && kind == 3'd2 && rs_eq_rt) |=> pc == $past(pc) + XLEN'(STEP));

  assert_region_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (!stall && kind == 3'd3) |=>
      (pc[XLEN-1 -: REGION_W] == $past(pc[XLEN-1 -: REGION_W])) &&
      (pc[ALIGN_W-1:0] == '0));

  assert_regjump_R7: assert property (@(posedge clk) disable iff (rst)
    (!stall && kind == 3'd4) |=> pc == $past(rs_val));

  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (pc[ALIGN_W-1:0] != '0));

  assert_flag_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (stall || kind != 3'd4) |=> !misalign);
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [31:0] offset = '0;
  logic [25:0] jfield = '0;
  logic [31:0] rs_val = '0;
  logic        rs_eq_rt = 1'b0;
  logic [31:0] pc, link;
  logic        misalign;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst(rst), .stall(stall), .kind(kind), .offset(offset),
    .jfield(jfield), .rs_val(rs_val), .rs_eq_rt(rs_eq_rt),
    .pc(pc), .link(link), .misalign(misalign)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply inputs, wait one edge, check pc, link and flag against model
  task automatic step(input string req, input logic [2:0] k, input logic [31:0] off,
                      input logic [25:0] jf, input logic [31:0] rs, input logic eq,
                      input logic st, input logic [31:0] exp_pc, input logic exp_mis);
    stall = st; kind = k; offset = off; jfield = jf; rs_val = rs; rs_eq_rt = eq;
    @(posedge clk); #1;
    chk(req, pc, exp_pc);
    chk(req, link, exp_pc + 32'd4);
    chk(req, {31'd0, misalign}, {31'd0, exp_mis});
    stall = 1'b0; kind = 3'd0;
  endtask

  task automatic goto_pc(input logic [31:0] a);
    step("R7", 3'd4, '0, '0, a, 1'b0, 1'b0, a, |a[1:0]);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R1", pc, 32'h0);
    chk("R1", {31'd0, misalign}, 32'd0);
    chk("R9", link, 32'h4);
    rst = 1'b0;
  endtask

  task automatic t_seq;
    for (int i = 1; i <= 4; i++)
      step("R2", 3'd0, 32'h1234, 26'h3, 32'h7, 1'b1, 1'b0, 32'(i * 4), 1'b0);
  endtask

  task automatic t_stall;
    logic [31:0] p;
    p = pc;
    step("R3", 3'd4, '0, '0, 32'h0000_1003, 1'b0, 1'b1, p, 1'b0);
    step("R3", 3'd3, '0, 26'h155, '0, 1'b0, 1'b1, p, 1'b0);
    step("R3", 3'd1, 32'h10, '0, '0, 1'b1, 1'b1, p, 1'b0);
  endtask

  task automatic t_beq;
    goto_pc(32'h0000_1000);
    step("R4", 3'd1, 32'h0000_0010, '0, '0, 1'b1, 1'b0, 32'h0000_1044, 1'b0);
    step("R4", 3'd1, 32'h0000_0010, '0, '0, 1'b0, 1'b0, 32'h0000_1048, 1'b0);
  endtask

  task automatic t_bne;
    goto_pc(32'h0000_2000);
    step("R5", 3'd2, 32'h0000_0008, '0, '0, 1'b0, 1'b0, 32'h0000_2024, 1'b0);
    step("R5", 3'd2, 32'h0000_0008, '0, '0, 1'b1, 1'b0, 32'h0000_2028, 1'b0);
  endtask

  task automatic t_back;
    goto_pc(32'h0000_2000);
    // offset -4 words: 0x2000+4-16
    step("R11", 3'd1, 32'hFFFF_FFFC, '0, '0, 1'b1, 1'b0, 32'h0000_1FF4, 1'b0);
    // offset at most negative 16-bit value
    step("R11", 3'd2, 32'hFFFF_8000, '0, '0, 1'b0, 1'b0, 32'hFFFE_1FF8, 1'b0);
    goto_pc(32'hFFFF_FFF8);
    step("R11", 3'd1, 32'h0000_0002, '0, '0, 1'b1, 1'b0, 32'h0000_0004, 1'b0);
  endtask

  task automatic t_jabs;
    goto_pc(32'hA000_0040);
    step("R6", 3'd3, '0, 26'h3FF_FFFF, '0, 1'b0, 1'b0, 32'hAFFF_FFFC, 1'b0);
    step("R6", 3'd3, '0, 26'h000_0123, '0, 1'b0, 1'b0, 32'hA000_048C, 1'b0);
  endtask

  task automatic t_misalign;
    step("R8", 3'd4, '0, '0, 32'h0000_3002, 1'b0, 1'b0, 32'h0000_3002, 1'b1);
    step("R8", 3'd0, '0, '0, '0, 1'b0, 1'b0, 32'h0000_3006, 1'b0);
    step("R8", 3'd4, '0, '0, 32'h0000_4001, 1'b0, 1'b1, 32'h0000_3006, 1'b0);
    step("R8", 3'd4, '0, '0, 32'h0000_5000, 1'b0, 1'b0, 32'h0000_5000, 1'b0);
  endtask

  task automatic t_wrap;
    goto_pc(32'hFFFF_FFF8);
    step("R2", 3'd0, '0, '0, '0, 1'b0, 1'b0, 32'hFFFF_FFFC, 1'b0);
    chk("R9", link, 32'h0000_0000);
    step("R2", 3'd0, '0, '0, '0, 1'b0, 1'b0, 32'h0000_0000, 1'b0);
  endtask

  task automatic t_unused;
    goto_pc(32'h0000_0100);
    step("R10", 3'd5, 32'h40, 26'h1, 32'h3, 1'b1, 1'b0, 32'h0000_0104, 1'b0);
    step("R10", 3'd6, 32'h40, 26'h1, 32'h3, 1'b0, 1'b0, 32'h0000_0108, 1'b0);
    step("R10", 3'd7, 32'h40, 26'h1, 32'h3, 1'b1, 1'b0, 32'h0000_010C, 1'b0);
  endtask

  task automatic t_reset_mid;
    goto_pc(32'h0000_0777);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", pc, 32'h0);
    chk("R1", {31'd0, misalign}, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_seq();
    t_stall();
    t_beq();
    t_bne();
    t_back();
    t_jabs();
    t_misalign();
    t_wrap();
    t_unused();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule